// File: doc/BRIEF.md
# Byte-Bus Successive-Approximation Converter Sequencer

This block runs an external 16-bit successive-approximation converter from the host side. The converter is controlled by an active-low select line, a level line that chooses between acquire/convert and read, a falling-edge completion flag, and a byte-steering pin on an 8-bit data bus. When a request is accepted, the sequencer first drops the select line with the level line low, which powers the converter and opens acquisition. It then raises the select line for a short gap and drops it a second time. That second edge starts the conversion, and the level present at that edge tells the converter whether to stay in standby or shut down once it finishes. When the completion flag falls, the sequencer reads the high byte, then the low byte, and presents the joined 16-bit word.

All delays are counted in system clock cycles and derived from a clock-frequency parameter. The sequencer remembers how the previous cycle ended. When that was a shutdown, the first select pulse is stretched to cover the reference wake-up time. This also applies after reset and after an aborted cycle. If the completion flag does not fall within a timeout, the sequencer releases the converter and sets a sticky error flag.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a request is taken on a cycle where both `req_valid` and `req_ready` are high. The result interface has no back-pressure. `res_valid` is a single-cycle pulse, and the consumer must take `res_data` in that cycle.

Top module: `sarb_host`

## Requirements
- R1: While reset is held and on the first cycle after it, `conv_sel_n` is 1, `req_ready` is 1, `res_valid` is 0 and `err_tmo` is 0; reset is the only thing that clears `err_tmo`.
- R2: The first falling edge of `conv_sel_n` in each cycle happens with `mode_ctl` at 0, on the cycle after the request is accepted.
- R3: At the second falling edge of `conv_sel_n`, `mode_ctl` equals the `req_shut` value captured with the request (1 = shut down after conversion, 0 = standby).
- R4: The first low pulse of `conv_sel_n` lasts `ACQ_CYC` cycles when the previous cycle ended in standby. It lasts the larger of `ACQ_CYC` and `WAKE_US*CLK_MHZ` cycles when the previous cycle ended in shutdown, after reset, or after a timeout.
- R5: If `done_n` stays high for `TMO_US*CLK_MHZ` cycles after the second falling edge, `conv_sel_n` rises after exactly that many low cycles. In that case `err_tmo` becomes 1 and stays 1, no result is produced, and the next cycle is treated as coming from shutdown.
- R6: After `done_n` falls, `byte_hi` goes to 1 first (high byte) and then to 0 (low byte). `res_data` = {high byte, low byte} is presented with `res_valid` high for exactly one cycle per completed conversion.
- R7: `adc_bus` is sampled `SETTLE_CYC` cycles after each change of `byte_hi`, and not earlier.
- R8: `req_ready` is 0 from acceptance until the cycle ends. Requests made while it is 0 start no extra cycle and do not change the mode of the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request |
| req_shut | input | 1 | Mode after conversion: 1 shutdown, 0 standby |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Converted word |
| err_tmo | output | 1 | Sticky completion-timeout flag |
| conv_sel_n | output | 1 | Converter select, active low |
| mode_ctl | output | 1 | Converter acquire/convert (0) or read/shutdown (1) level |
| byte_hi | output | 1 | Byte steering: 1 high byte, 0 low byte |
| done_n | input | 1 | Converter completion flag, falls when done |
| adc_bus | input | 8 | Converter data byte |

## Verification
The bench models the converter at the pins. The model only drives valid data once `byte_hi` has been stable long enough, so a sequencer that samples early captures a zero byte instead of the expected word. The model measures each select pulse, which exposes a wake-up stretch that is skipped after reset, after a shutdown or after a timeout, and one that is wrongly applied after standby. It also records the mode level at both falling edges, so an inverted or late mode level and a busy-time request that leaks into the running cycle both show up as wrong mode or start counts. A hung converter checks the timeout length, the sticky flag surviving a later good conversion, and the absence of a result strobe.

// File: rtl/sarb_pkg.sv
package sarb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_GAP,
    ST_CONV,
    ST_RDH,
    ST_RDL
  } sarb_state_t;
endpackage

// File: rtl/sarb_timer.sv
module sarb_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sarb_mode_track.sv
module sarb_mode_track (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic req_shut,
  input  logic finish,
  input  logic abort,
  output logic pend_shut,
  output logic prev_shut
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_shut <= 1'b0;
      prev_shut <= 1'b1;
    end else begin
      if (accept) pend_shut <= req_shut;
      if (abort)       prev_shut <= 1'b1;
      else if (finish) prev_shut <= pend_shut;
    end
  end
endmodule

// File: rtl/sarb_byte_asm.sv
module sarb_byte_asm #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_hi,
  input  logic          cap_lo,
  input  logic [BW-1:0] bus,
  output logic          res_valid,
  output logic [2*BW-1:0] res_data
);
  logic [BW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= cap_lo;
      if (cap_hi) hi_q <= bus;
      if (cap_lo) res_data <= {hi_q, bus};
    end
  end
endmodule

// File: rtl/sarb_host.sv
module sarb_host
  import sarb_pkg::*;
#(
  parameter int CLK_MHZ    = 50,
  parameter int WAKE_US    = 12000,
  parameter int TMO_US     = 20,
  parameter int ACQ_CYC    = 50,
  parameter int GAP_CYC    = 4,
  parameter int SETTLE_CYC = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_shut,
  output logic        req_ready,
  output logic        res_valid,
  output logic [15:0] res_data,
  output logic        err_tmo,
  output logic        conv_sel_n,
  output logic        mode_ctl,
  output logic        byte_hi,
  input  logic        done_n,
  input  logic [7:0]  adc_bus
);
  localparam int WAKE_CYC  = WAKE_US * CLK_MHZ;
  localparam int TMO_CYC   = TMO_US * CLK_MHZ;
  localparam int FIRST_CYC = (WAKE_CYC > ACQ_CYC) ? WAKE_CYC : ACQ_CYC;
  localparam int MAX_A     = (FIRST_CYC > TMO_CYC) ? FIRST_CYC : TMO_CYC;
  localparam int MAX_B     = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] L_FIRST = CNT_W'(FIRST_CYC - 1);
  localparam logic [CNT_W-1:0] L_ACQ   = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] L_GAP   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] L_TMO   = CNT_W'(TMO_CYC - 1);
  localparam logic [CNT_W-1:0] L_SET   = CNT_W'(SETTLE_CYC - 1);

  sarb_state_t       state, nxt;
  logic              load, zero;
  logic [CNT_W-1:0]  load_val;
  logic              accept, finish, abort, cap_hi, cap_lo;
  logic              pend_shut, prev_shut;

  assign accept = req_valid && (state == ST_IDLE);

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = L_SET;
    finish   = 1'b0;
    abort    = 1'b0;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) begin
        nxt      = ST_ACQ;
        load     = 1'b1;
        load_val = prev_shut ? L_FIRST : L_ACQ;
      end
      ST_ACQ: if (zero) begin
        nxt = ST_GAP; load = 1'b1; load_val = L_GAP;
      end
      ST_GAP: if (zero) begin
        nxt = ST_CONV; load = 1'b1; load_val = L_TMO;
      end
      ST_CONV: begin
        if (!done_n) begin
          nxt = ST_RDH; load = 1'b1; load_val = L_SET;
        end else if (zero) begin
          nxt = ST_IDLE; abort = 1'b1;
        end
      end
      ST_RDH: if (zero) begin
        nxt = ST_RDL; load = 1'b1; load_val = L_SET; cap_hi = 1'b1;
      end
      ST_RDL: if (zero) begin
        nxt = ST_IDLE; cap_lo = 1'b1; finish = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      err_tmo <= 1'b0;
    end else begin
      state <= nxt;
      if (abort) err_tmo <= 1'b1;
    end
  end

  sarb_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(zero)
  );

  sarb_mode_track u_mode (
    .clk(clk), .rst(rst), .accept(accept), .req_shut(req_shut),
    .finish(finish), .abort(abort), .pend_shut(pend_shut), .prev_shut(prev_shut)
  );

  sarb_byte_asm #(.BW(8)) u_asm (
    .clk(clk), .rst(rst), .cap_hi(cap_hi), .cap_lo(cap_lo), .bus(adc_bus),
    .res_valid(res_valid), .res_data(res_data)
  );

  assign req_ready  = (state == ST_IDLE);
  assign conv_sel_n = (state == ST_IDLE) || (state == ST_GAP);
  assign byte_hi    = (state == ST_RDH);
  assign mode_ctl   = ((state == ST_GAP) || (state == ST_CONV)) ? pend_shut :
                      ((state == ST_RDH) || (state == ST_RDL));
endmodule

// File: rtl/sarb_host_chk.sv
module sarb_host_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic res_valid,
  input logic err_tmo,
  input logic conv_sel_n,
  input logic mode_ctl
);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!conv_sel_n && !mode_ctl));

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_released_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> conv_sel_n);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    err_tmo |=> err_tmo);

  assert_abort_nores_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(err_tmo) |-> (!res_valid && conv_sel_n));
endmodule

bind sarb_host sarb_host_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .err_tmo(err_tmo), .conv_sel_n(conv_sel_n),
  .mode_ctl(mode_ctl)
);

// File: tb/sarb_host_test.sv
module sarb_host_test;
  localparam int CLK_MHZ = 50, WAKE_US = 20, TMO_US = 4;
  localparam int ACQ_CYC = 20, GAP_CYC = 4, SETTLE_CYC = 3;
  localparam int WAKE_CYC = WAKE_US * CLK_MHZ;
  localparam int TMO_CYC  = TMO_US * CLK_MHZ;
  localparam int CONV_DLY = 60;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_shut = 1'b0;
  logic req_ready, res_valid, err_tmo, conv_sel_n, mode_ctl, byte_hi;
  logic [15:0] res_data;
  logic done_n = 1'b1;
  logic [7:0] adc_bus;

  int vectors = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  sarb_host #(.CLK_MHZ(CLK_MHZ), .WAKE_US(WAKE_US), .TMO_US(TMO_US),
    .ACQ_CYC(ACQ_CYC), .GAP_CYC(GAP_CYC), .SETTLE_CYC(SETTLE_CYC)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_shut(req_shut),
    .req_ready(req_ready), .res_valid(res_valid), .res_data(res_data),
    .err_tmo(err_tmo), .conv_sel_n(conv_sel_n), .mode_ctl(mode_ctl),
    .byte_hi(byte_hi), .done_n(done_n), .adc_bus(adc_bus)
  );

  // converter model
  logic cs_q = 1'b1, hb_q = 1'b0, hang = 1'b0, hb_seen = 1'b0, hb_first = 1'b0;
  logic first_mode = 1'b1, second_mode = 1'b0;
  logic [15:0] val = 16'h0;
  int edges = 0, lowrun = 0, acq_len = 0, low2_len = 0, ccnt = 0, age = 0;
  int starts = 0, pulses = 0;
  logic [15:0] got = 16'h0;

  assign adc_bus = conv_sel_n ? 8'hzz :
                   (done_n || byte_hi != hb_q || age < SETTLE_CYC - 2) ? 8'h00 :
                   (byte_hi ? val[15:8] : val[7:0]);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cs_q <= conv_sel_n;
    hb_q <= byte_hi;
    age  <= (byte_hi != hb_q) ? 0 : age + 1;
    if (byte_hi != hb_q && !hb_seen) begin hb_seen <= 1'b1; hb_first <= byte_hi; end
    if (res_valid) begin pulses <= pulses + 1; got <= res_data; end
    if (!conv_sel_n) begin
      lowrun <= lowrun + 1;
      if (cs_q) begin
        if (edges == 0) begin edges <= 1; first_mode <= mode_ctl; starts <= starts + 1; end
        else begin edges <= 2; second_mode <= mode_ctl; ccnt <= 0; end
      end else if (edges == 2) begin
        ccnt <= ccnt + 1;
        if (ccnt == CONV_DLY && !hang) done_n <= 1'b0;
      end
    end else begin
      lowrun <= 0;
      if (!cs_q) begin
        if (edges == 1) acq_len <= lowrun;
        else if (edges == 2) begin low2_len <= lowrun; edges <= 0; done_n <= 1'b1; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    starts = 0; pulses = 0; hb_seen = 1'b0; acq_len = -1; low2_len = -1;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!req_ready && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic launch(input logic shut);
    @(negedge clk);
    req_valid = 1'b1; req_shut = shut;
    @(negedge clk);
    req_valid = 1'b0; req_shut = 1'b0;
  endtask

  task automatic conv_ok(input logic shut, input int exp_acq, input logic [15:0] v);
    clear_stats(); val = v; hang = 1'b0;
    launch(shut);
    wait_idle();
    check(first_mode == 1'b0, "R2", first_mode, 0);
    check(acq_len == exp_acq, "R4", acq_len, exp_acq);
    check(second_mode == shut, "R3", second_mode, shut);
    check(hb_first == 1'b1, "R6", hb_first, 1);
    check(pulses == 1, "R6", pulses, 1);
    check(got == v, "R7", got, v);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(conv_sel_n == 1'b1, "R1", conv_sel_n, 1);
    check(req_ready == 1'b1, "R1", req_ready, 1);
    check(res_valid == 1'b0, "R1", res_valid, 0);
    check(err_tmo == 1'b0, "R1", err_tmo, 0);
  endtask

  task automatic t_busy();
    clear_stats(); val = 16'h1E2D; hang = 1'b0;
    launch(1'b0);
    repeat (5) @(negedge clk);
    check(req_ready == 1'b0, "R8", req_ready, 0);
    req_valid = 1'b1; req_shut = 1'b1;
    repeat (ACQ_CYC + 10) @(negedge clk);
    req_valid = 1'b0; req_shut = 1'b0;
    wait_idle();
    check(starts == 1, "R8", starts, 1);
    check(second_mode == 1'b0, "R8", second_mode, 0);
    check(pulses == 1 && got == 16'h1E2D, "R8", got, 16'h1E2D);
  endtask

  task automatic t_timeout();
    clear_stats(); hang = 1'b1;
    launch(1'b0);
    wait_idle();
    check(low2_len == TMO_CYC, "R5", low2_len, TMO_CYC);
    check(err_tmo == 1'b1, "R5", err_tmo, 1);
    check(pulses == 0, "R5", pulses, 0);
    check(conv_sel_n == 1'b1, "R5", conv_sel_n, 1);
    hang = 1'b0;
    conv_ok(1'b0, WAKE_CYC, 16'h7B84);
    check(err_tmo == 1'b1, "R5", err_tmo, 1);
  endtask

  task automatic t_reset_clears();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(err_tmo == 1'b0, "R1", err_tmo, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    conv_ok(1'b0, WAKE_CYC, 16'hA55A);   // first after reset: full wake
    conv_ok(1'b1, ACQ_CYC, 16'h3CC3);    // after standby: short acquire
    conv_ok(1'b0, WAKE_CYC, 16'hF00F);   // after shutdown: full wake
    t_busy();
    t_timeout();
    t_reset_clears();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    vectors++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule